// File: doc/BRIEF.md
# Video Active Region Timing Generator

This block tracks the position of each sample within an interlaced video frame. It counts samples along a line and lines down a frame. From those counts it derives a horizontal active flag, a vertical active flag, their combination, a field indicator and a one-cycle pulse that marks each new line. Four line standards can be selected: 525 or 625 lines per frame, each with a rectangular-pixel or a square-pixel sample count per line.

The counters step only on clock cycles where the sample-enable input is high. This lets the block follow a stream whose samples arrive in irregular bursts. A new standard selection is held back until the current frame has finished. The block never switches geometry part of the way through a frame. It does not detect sync and does not lock to incoming video. It only counts.

Top module: `vtg_timing`

## Requirements
- R1: `pix_idx` counts enabled samples from 0 to total-1 and then wraps to 0. `line_num` is 1-based. It advances by one at each pixel wrap and returns to 1 after the frame's last line (525 or 625). Both outputs reflect an enabled edge in the cycle that follows that edge.
- R2: The `std_sel` encoding is as follows. 0 selects 525 lines with 858 samples per line and 720 active. 1 selects 525 lines with 780 samples per line and 640 active. 2 selects 625 lines with 864 samples per line and 720 active. 3 selects 625 lines with 944 samples per line and 768 active.
- R3: In a cycle with `smp_en` low, no counter and no output changes, and `line_start` is 0.
- R4: `h_active` is high exactly for pixel indices from total-active-FRONT_PORCH up to total-FRONT_PORCH-1.
- R5: For 525-line standards, `v_active` is high exactly on lines 23 to 262 and 285 to 524.
- R6: For 625-line standards, `v_active` is high exactly on lines 23 to 310 and 336 to 623.
- R7: `field_even` is 0 from line 1 up to the line before the second field's blanking. It is 1 from line 263 (525-line standards) or line 311 (625-line standards) through the last line.
- R8: `active` is high only when `h_active` and `v_active` are both high.
- R9: `line_start` is high for exactly the one cycle in which `pix_idx` has just wrapped to 0. It is not raised by reset.
- R10: `std_sel` is sampled during reset and at the frame wrap, when the last sample of the last line is enabled. A change at any other time has no effect on the counts or flags of the frame in progress.
- R11: While reset is asserted and after it is released, `pix_idx` is 0, `line_num` is 1, and `v_active`, `active`, `field_even` and `line_start` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample enable; counters advance on cycles where it is high |
| std_sel | input | 2 | Standard selection (encoding in R2) |
| pix_idx | output | PIX_W | Sample index within the line |
| line_num | output | LINE_W | Line number within the frame, 1-based |
| h_active | output | 1 | Sample lies in the horizontal active window |
| v_active | output | 1 | Line lies in an active line range |
| active | output | 1 | Both horizontal and vertical active |
| field_even | output | 1 | Second field indicator |
| line_start | output | 1 | One-cycle pulse when a new line begins |

## Verification
Every output is a register that is loaded on the same edge as the counters. The effect of an enabled sample therefore appears one cycle later. The bench drives inputs on the falling edge and checks all outputs 1 ns after the following rising edge. It compares them against a count of enabled samples, from which it derives the expected pixel, line and flag values. A standard change is expected only after the modelled frame wrap, and `line_start` is expected only in the cycle of a modelled pixel wrap. Idle cycles have no effect on the model, so every cycle checks that the outputs held their values.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [1:0] {
    STD_525_RECT = 2'd0,
    STD_525_SQR  = 2'd1,
    STD_625_RECT = 2'd2,
    STD_625_SQR  = 2'd3
  } vtg_std_e;

  localparam int unsigned LINES_525 = 525;
  localparam int unsigned LINES_625 = 625;

  // Active line ranges (first field, second field)
  localparam int unsigned V525_F1_FIRST = 23;
  localparam int unsigned V525_F1_LAST  = 262;
  localparam int unsigned V525_F2_FIRST = 285;
  localparam int unsigned V525_F2_LAST  = 524;
  localparam int unsigned V625_F1_FIRST = 23;
  localparam int unsigned V625_F1_LAST  = 310;
  localparam int unsigned V625_F2_FIRST = 336;
  localparam int unsigned V625_F2_LAST  = 623;

  // First line of the second field's blanking, where the field flag flips
  localparam int unsigned FLIP_525 = 263;
  localparam int unsigned FLIP_625 = 311;

  function automatic logic std_is_625(vtg_std_e s);
    return s[1];
  endfunction

  function automatic logic line_visible(int unsigned ln, logic is625);
    if (is625)
      return (ln >= V625_F1_FIRST && ln <= V625_F1_LAST) ||
             (ln >= V625_F2_FIRST && ln <= V625_F2_LAST);
    return (ln >= V525_F1_FIRST && ln <= V525_F1_LAST) ||
           (ln >= V525_F2_FIRST && ln <= V525_F2_LAST);
  endfunction

  function automatic logic line_second_field(int unsigned ln, logic is625);
    return ln >= (is625 ? FLIP_625 : FLIP_525);
  endfunction

endpackage

// File: rtl/vtg_wrap_cnt.sv
module vtg_wrap_cnt #(
  parameter int W    = 10,
  parameter int BASE = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] BASE_V = W'(BASE);

  assign wrap_o = en && (q_o == last_i);

  always_comb begin
    if (!en)        nxt_o = q_o;
    else if (wrap_o) nxt_o = BASE_V;
    else            nxt_o = q_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= BASE_V;
    else     q_o <= nxt_o;
  end

endmodule

// File: rtl/vtg_hgeom.sv
module vtg_hgeom
  import vtg_pkg::*;
#(
  parameter int PIX_W   = 10,
  parameter int TOT_0   = 858,
  parameter int ACT_0   = 720,
  parameter int TOT_1   = 780,
  parameter int ACT_1   = 640,
  parameter int TOT_2   = 864,
  parameter int ACT_2   = 720,
  parameter int TOT_3   = 944,
  parameter int ACT_3   = 768,
  parameter int FRONT_PORCH = 16
) (
  input  vtg_std_e         std_cur_i,
  input  vtg_std_e         std_eval_i,
  output logic [PIX_W-1:0] tot_m1_o,
  output logic [PIX_W-1:0] h_first_o,
  output logic [PIX_W-1:0] h_last_o
);

  localparam int NSTD = 4;
  localparam int TOT_T [NSTD] = '{TOT_0, TOT_1, TOT_2, TOT_3};
  localparam int ACT_T [NSTD] = '{ACT_0, ACT_1, ACT_2, ACT_3};

  logic [PIX_W-1:0] tab_m1    [NSTD];
  logic [PIX_W-1:0] tab_first [NSTD];
  logic [PIX_W-1:0] tab_last  [NSTD];

  for (genvar g = 0; g < NSTD; g++) begin : g_std
    assign tab_m1[g]    = PIX_W'(TOT_T[g] - 1);
    assign tab_first[g] = PIX_W'(TOT_T[g] - ACT_T[g] - FRONT_PORCH);
    assign tab_last[g]  = PIX_W'(TOT_T[g] - FRONT_PORCH - 1);
  end

  assign tot_m1_o  = tab_m1[2'(std_cur_i)];
  assign h_first_o = tab_first[2'(std_eval_i)];
  assign h_last_o  = tab_last[2'(std_eval_i)];

endmodule

// File: rtl/vtg_region.sv
module vtg_region
  import vtg_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int LINE_W = 10
) (
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [LINE_W-1:0] line_i,
  input  vtg_std_e          std_i,
  input  logic [PIX_W-1:0]  h_first_i,
  input  logic [PIX_W-1:0]  h_last_i,
  output logic              h_act_o,
  output logic              v_act_o,
  output logic              fld_o
);

  logic is625;

  assign is625   = std_is_625(std_i);
  assign h_act_o = (pix_i >= h_first_i) && (pix_i <= h_last_i);
  assign v_act_o = line_visible(32'(line_i), is625);
  assign fld_o   = line_second_field(32'(line_i), is625);

endmodule

// File: rtl/vtg_timing.sv
module vtg_timing
  import vtg_pkg::*;
#(
  parameter int PIX_W       = 10,
  parameter int LINE_W      = 10,
  parameter int TOT_0       = 858,
  parameter int ACT_0       = 720,
  parameter int TOT_1       = 780,
  parameter int ACT_1       = 640,
  parameter int TOT_2       = 864,
  parameter int ACT_2       = 720,
  parameter int TOT_3       = 944,
  parameter int ACT_3       = 768,
  parameter int FRONT_PORCH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_en,
  input  logic [1:0]        std_sel,
  output logic [PIX_W-1:0]  pix_idx,
  output logic [LINE_W-1:0] line_num,
  output logic              h_active,
  output logic              v_active,
  output logic              active,
  output logic              field_even,
  output logic              line_start
);

  localparam logic [LINE_W-1:0] LAST_525 = LINE_W'(LINES_525);
  localparam logic [LINE_W-1:0] LAST_625 = LINE_W'(LINES_625);
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  vtg_std_e          std_in, std_cur, std_next, std_eval;
  logic [PIX_W-1:0]  pix_nxt, tot_m1, h_first, h_last, pix_eval;
  logic [LINE_W-1:0] line_nxt, line_last, line_eval;
  logic              pix_wrap, frame_wrap;
  logic              h_eval, v_eval, f_eval;

  assign std_in    = vtg_std_e'(std_sel);
  assign line_last = std_is_625(std_cur) ? LAST_625 : LAST_525;
  assign std_next  = frame_wrap ? std_in : std_cur;

  // Geometry for the next cycle; during reset the state being loaded is used
  assign std_eval  = rst ? std_in   : std_next;
  assign pix_eval  = rst ? '0       : pix_nxt;
  assign line_eval = rst ? LINE_ONE : line_nxt;

  vtg_hgeom #(
    .PIX_W(PIX_W), .TOT_0(TOT_0), .ACT_0(ACT_0), .TOT_1(TOT_1), .ACT_1(ACT_1),
    .TOT_2(TOT_2), .ACT_2(ACT_2), .TOT_3(TOT_3), .ACT_3(ACT_3),
    .FRONT_PORCH(FRONT_PORCH)
  ) u_geom (
    .std_cur_i (std_cur),
    .std_eval_i(std_eval),
    .tot_m1_o  (tot_m1),
    .h_first_o (h_first),
    .h_last_o  (h_last)
  );

  vtg_wrap_cnt #(.W(PIX_W), .BASE(0)) u_pix_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (smp_en),
    .last_i(tot_m1),
    .q_o   (pix_idx),
    .nxt_o (pix_nxt),
    .wrap_o(pix_wrap)
  );

  vtg_wrap_cnt #(.W(LINE_W), .BASE(1)) u_line_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (pix_wrap),
    .last_i(line_last),
    .q_o   (line_num),
    .nxt_o (line_nxt),
    .wrap_o(frame_wrap)
  );

  vtg_region #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_region (
    .pix_i    (pix_eval),
    .line_i   (line_eval),
    .std_i    (std_eval),
    .h_first_i(h_first),
    .h_last_i (h_last),
    .h_act_o  (h_eval),
    .v_act_o  (v_eval),
    .fld_o    (f_eval)
  );

  always_ff @(posedge clk) begin
    std_cur    <= std_eval;
    h_active   <= h_eval;
    v_active   <= v_eval;
    active     <= h_eval && v_eval;
    field_even <= f_eval;
    line_start <= !rst && pix_wrap;
  end

endmodule

// File: rtl/vtg_timing_chk.sv
module vtg_timing_chk #(
  parameter int PIX_W  = 10,
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_en,
  input logic [PIX_W-1:0]  pix_idx,
  input logic [LINE_W-1:0] line_num,
  input logic              h_active,
  input logic              v_active,
  input logic              active,
  input logic              field_even,
  input logic              line_start
);

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> (pix_idx == $past(pix_idx) + 1'b1) || (pix_idx == '0 && line_start)); // R1

  AST_LINE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    line_num != '0); // R1

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (line_num == $past(line_num) + 1'b1) || (line_num == LINE_W'(1))); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(pix_idx) && $stable(line_num) && $stable(active) && !line_start); // R3

  AST_VACT_ROWS: assert property (@(posedge clk) disable iff (rst)
    v_active |-> line_num >= LINE_W'(23)); // R5

  AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (rst)
    $rose(field_even) |-> pix_idx == '0 &&
      (line_num == LINE_W'(263) || line_num == LINE_W'(311))); // R7

  AST_ACTIVE_BOTH: assert property (@(posedge clk) disable iff (rst)
    active |-> h_active && v_active); // R8

  AST_LSTART_PIX0: assert property (@(posedge clk) disable iff (rst)
    line_start |-> pix_idx == '0); // R9

  AST_LSTART_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start); // R9

endmodule

bind vtg_timing vtg_timing_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/vtg_timing_bench.sv
`timescale 1ns/1ps
module vtg_timing_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_s  [2];
  logic       en_s   [2];
  logic [1:0] std_s  [2];
  logic [9:0] pix_o  [2];
  logic [9:0] line_o [2];
  logic       ha_o [2], va_o [2], act_o [2], fe_o [2], ls_o [2];

  int nchk = 0;
  int nfail = 0;
  int k    [2];
  int estd [2];
  bit wrapped [2];

  // Full-geometry instance
  vtg_timing u_vtg_timing (
    .clk(clk), .rst(rst_s[0]), .smp_en(en_s[0]), .std_sel(std_s[0]),
    .pix_idx(pix_o[0]), .line_num(line_o[0]), .h_active(ha_o[0]),
    .v_active(va_o[0]), .active(act_o[0]), .field_even(fe_o[0]),
    .line_start(ls_o[0]));

  // Short lines so whole frames fit in the run
  vtg_timing #(
    .TOT_0(16), .ACT_0(10), .TOT_1(14), .ACT_1(8),
    .TOT_2(18), .ACT_2(12), .TOT_3(20), .ACT_3(14), .FRONT_PORCH(2)
  ) u_vtg_small (
    .clk(clk), .rst(rst_s[1]), .smp_en(en_s[1]), .std_sel(std_s[1]),
    .pix_idx(pix_o[1]), .line_num(line_o[1]), .h_active(ha_o[1]),
    .v_active(va_o[1]), .active(act_o[1]), .field_even(fe_o[1]),
    .line_start(ls_o[1]));

  function automatic int tot_of(int id, int s);
    int big [4] = '{858, 780, 864, 944};
    int sml [4] = '{16, 14, 18, 20};
    return id == 0 ? big[s] : sml[s];
  endfunction

  function automatic int act_of(int id, int s);
    int big [4] = '{720, 640, 720, 768};
    int sml [4] = '{10, 8, 12, 14};
    return id == 0 ? big[s] : sml[s];
  endfunction

  function automatic int fp_of(int id);
    return id == 0 ? 16 : 2;
  endfunction

  function automatic int lines_of(int s);
    return s >= 2 ? 625 : 525;
  endfunction

  task automatic chk(string tag, int id, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s inst%0d k=%0d actual=%0d expected=%0d", tag, id, k[id], act, exp);
    end
  endtask

  task automatic compare(int id, bit ls);
    int t  = tot_of(id, estd[id]);
    int a  = act_of(id, estd[id]);
    int f  = fp_of(id);
    int p  = k[id] % t;
    int ln = k[id] / t + 1;
    bit is625 = estd[id] >= 2;
    bit ha = (p >= t - a - f) && (p < t - f);
    bit va = is625 ? ((ln >= 23 && ln <= 310) || (ln >= 336 && ln <= 623))
                   : ((ln >= 23 && ln <= 262) || (ln >= 285 && ln <= 524));
    bit fe = ln >= (is625 ? 311 : 263);
    chk("R1 R2 R3 R10 pix_idx", id, int'(pix_o[id]), p);
    chk("R1 R3 R10 line_num", id, int'(line_o[id]), ln);
    chk("R4 h_active", id, int'(ha_o[id]), int'(ha));
    chk(is625 ? "R6 v_active" : "R5 v_active", id, int'(va_o[id]), int'(va));
    chk("R8 active", id, int'(act_o[id]), int'(ha && va));
    chk("R7 field_even", id, int'(fe_o[id]), int'(fe));
    chk("R9 line_start", id, int'(ls_o[id]), int'(ls));
  endtask

  task automatic tick(int id, bit e, int s);
    bit ls = 1'b0;
    @(negedge clk);
    en_s[id]  = e;
    std_s[id] = 2'(s);
    @(posedge clk);
    if (e) begin
      k[id]++;
      if (k[id] % tot_of(id, estd[id]) == 0) ls = 1'b1;
      if (k[id] == tot_of(id, estd[id]) * lines_of(estd[id])) begin
        k[id] = 0;
        estd[id] = s;
        wrapped[id] = 1'b1;
      end
    end
    #1 compare(id, ls);
  endtask

  task automatic do_reset(int id, int s);
    @(negedge clk);
    rst_s[id] = 1'b1;
    en_s[id]  = 1'b0;
    std_s[id] = 2'(s);
    repeat (2) @(posedge clk);
    #1;
    chk("R11 pix in reset", id, int'(pix_o[id]), 0);
    chk("R11 line in reset", id, int'(line_o[id]), 1);
    @(negedge clk);
    rst_s[id] = 1'b0;
    k[id] = 0;
    estd[id] = s;
    @(posedge clk);
    #1;
    chk("R11 pix after reset", id, int'(pix_o[id]), 0);
    chk("R11 line after reset", id, int'(line_o[id]), 1);
    chk("R11 v_active after reset", id, int'(va_o[id]), 0);
    chk("R11 active after reset", id, int'(act_o[id]), 0);
    chk("R11 field_even after reset", id, int'(fe_o[id]), 0);
    chk("R11 line_start after reset", id, int'(ls_o[id]), 0);
  endtask

  task automatic run_big();
    for (int s = 0; s < 4; s++) begin
      do_reset(0, s);
      // Past the first active line, with occasional idle cycles
      for (int i = 0; i < 23 * tot_of(0, s) + 200; i++)
        tick(0, (i % 97) != 50, (i > 1000) ? 3 - s : s);
    end
  endtask

  task automatic run_small();
    int seq [5] = '{0, 3, 2, 1, 1};
    int i = 0;
    do_reset(1, 0);
    for (int fr = 0; fr < 4; fr++) begin
      wrapped[1] = 1'b0;
      while (!wrapped[1]) begin
        i++;
        // Mid-frame request for the next standard; must wait for the wrap (R10)
        tick(1, (i % 4) != 3, (k[1] >= 50) ? seq[fr + 1] : seq[fr]);
      end
      chk("R10 standard taken at frame wrap", 1, estd[1], seq[fr + 1]);
    end
  endtask

  initial begin
    for (int j = 0; j < 2; j++) begin
      rst_s[j] = 1'b1; en_s[j] = 1'b0; std_s[j] = 2'd0; k[j] = 0; estd[j] = 0; wrapped[j] = 1'b0;
    end
    fork
      run_big();
      run_small();
    join
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule